// File: doc/BRIEF.md
# Single-Bus Register Move Unit

This block holds four general-purpose registers that share one internal data bus. A four-bit instruction field names a source register and a destination register. The source register's contents are placed on the bus. When the transfer strobe is high, the destination register captures the bus value at the next rising clock edge. The result is the move `Ry <= Rx`.

The bus behaves as a shared line that only one register may drive at a time. It is built as an AND-OR selector fed by one-hot drive enables. It uses no real three-state pins, so it has no floating or contended states.

A separate preload port lets a test environment write any register directly. The preload takes effect only in cycles where the transfer strobe is low. The data width is a parameter. The four register values and the bus value are visible at the outputs. The block does not fetch instructions and performs no arithmetic.

Top module: `regmove_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registers become zero.
- R2: `bus_q` equals the register whose index is `instr[1:0]`, in the same cycle and with no clock delay. Exactly one source drive enable is active at any time.
- R3: If `xfer` is high at a rising edge, the register indexed by `instr[3:2]` loads the value that `bus_q` held before that edge.
- R4: During a transfer, every register other than the destination keeps its value, and at most one destination load is active.
- R5: If `xfer` and `pl_we` are both low at an edge, no register changes, whatever the value of `instr`.
- R6: If `instr[3:2]` equals `instr[1:0]` during a transfer, that register keeps its value.
- R7: If `pl_we` is high and `xfer` is low at an edge, the register indexed by `pl_sel` loads `pl_data` and the other registers hold.
- R8: If `pl_we` and `xfer` are both high, the preload is ignored and only the move takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 4 | Bits [1:0] give the source index; bits [3:2] give the destination index |
| xfer | input | 1 | Transfer strobe that gates every destination load |
| pl_we | input | 1 | Preload write enable for test |
| pl_sel | input | 2 | Index of the register to preload |
| pl_data | input | DATA_W | Value to preload |
| reg_q | output | 4*DATA_W | Register contents; register k occupies bits [k*DATA_W +: DATA_W] |
| bus_q | output | DATA_W | Current value on the shared bus |

## Verification
A source decode error appears on `bus_q` in the same cycle, before any clock edge, because the bus is compared right after each change of `instr`. A wrong destination decode, or a load that is not gated by the strobe, corrupts a register at the following edge. The next comparison of all four words then exposes it, within one cycle. Register damage that is hidden at first still surfaces the next time that register is chosen as the source, because its value is then copied to another register.

// File: rtl/regmove_pkg.sv
package regmove_pkg;
  localparam int SEL_W    = 2;
  localparam int NUM_REGS = 1 << SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src;
  } move_field_t;
endpackage

// File: rtl/regmove_dec.sv
module regmove_dec #(
  parameter int W = 2,
  parameter int N = 1 << W
) (
  input  logic [W-1:0] code,
  input  logic         en,
  output logic [N-1:0] hot
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign hot[g] = en && (code == W'(g));
  end
endmodule

// File: rtl/regmove_bus.sv
module regmove_bus #(
  parameter int DW = 8,
  parameter int N  = 4
) (
  input  logic [N*DW-1:0] words,
  input  logic [N-1:0]    drv,
  output logic [DW-1:0]   bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      if (drv[i]) bus = bus | words[i*DW +: DW];
    end
  end
endmodule

// File: rtl/regmove_regs.sv
module regmove_regs #(
  parameter int DW = 8,
  parameter int N  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    load,
  input  logic [DW-1:0]   d,
  input  logic [N-1:0]    pl_load,
  input  logic [DW-1:0]   pl_d,
  output logic [N*DW-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)             q[g*DW +: DW] <= '0;
      else if (load[g])    q[g*DW +: DW] <= d;
      else if (pl_load[g]) q[g*DW +: DW] <= pl_d;
    end
  end
endmodule

// File: rtl/regmove_unit.sv
module regmove_unit #(
  parameter int DATA_W = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [2*regmove_pkg::SEL_W-1:0]          instr,
  input  logic                                     xfer,
  input  logic                                     pl_we,
  input  logic [regmove_pkg::SEL_W-1:0]            pl_sel,
  input  logic [DATA_W-1:0]                        pl_data,
  output logic [regmove_pkg::NUM_REGS*DATA_W-1:0]  reg_q,
  output logic [DATA_W-1:0]                        bus_q
);
  import regmove_pkg::*;

  localparam int N = NUM_REGS;

  move_field_t   fld;
  logic [N-1:0]  src_en;
  logic [N-1:0]  dst_ld;
  logic [N-1:0]  pre_ld;

  assign fld = move_field_t'(instr);

  regmove_dec #(.W(SEL_W), .N(N)) u_src_dec (
    .code (fld.src),
    .en   (1'b1),
    .hot  (src_en)
  );

  regmove_dec #(.W(SEL_W), .N(N)) u_dst_dec (
    .code (fld.dst),
    .en   (xfer),
    .hot  (dst_ld)
  );

  regmove_dec #(.W(SEL_W), .N(N)) u_pre_dec (
    .code (pl_sel),
    .en   (pl_we && !xfer),
    .hot  (pre_ld)
  );

  regmove_bus #(.DW(DATA_W), .N(N)) u_bus (
    .words (reg_q),
    .drv   (src_en),
    .bus   (bus_q)
  );

  regmove_regs #(.DW(DATA_W), .N(N)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load    (dst_ld),
    .d       (bus_q),
    .pl_load (pre_ld),
    .pl_d    (pl_data),
    .q       (reg_q)
  );

  // Checker state: remembers the last write so its effect can be checked one edge later.
  logic              chk_mv;
  logic              chk_pl;
  logic [SEL_W-1:0]  chk_idx;
  logic [DATA_W-1:0] chk_val;

  always_ff @(posedge clk) begin
    chk_mv  <= !rst && xfer;
    chk_pl  <= !rst && !xfer && pl_we;
    chk_idx <= xfer ? fld.dst : pl_sel;
    chk_val <= xfer ? bus_q : pl_data;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> reg_q == '0); // R1
  AST_SRC_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot(src_en)); // R2
  AST_MOVE_LANDS: assert property (@(posedge clk) disable iff (rst)
    chk_mv |-> reg_q[chk_idx*DATA_W +: DATA_W] == chk_val); // R3
  AST_DST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot0(dst_ld)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!xfer && !pl_we) |=> $stable(reg_q)); // R5
  AST_PRELOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
    chk_pl |-> reg_q[chk_idx*DATA_W +: DATA_W] == chk_val); // R7
  AST_PRELOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    xfer |-> pre_ld == '0); // R8
endmodule

// File: tb/regmove_unit_test.sv
module regmove_unit_test;
  localparam int DW = 8;
  localparam int NR = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [3:0]      instr;
  logic            xfer;
  logic            pl_we;
  logic [1:0]      pl_sel;
  logic [DW-1:0]   pl_data;
  logic [NR*DW-1:0] reg_q;
  logic [DW-1:0]   bus_q;

  int tests = 0;
  int fails = 0;
  int unsigned model [NR];

  always #2 clk = ~clk;

  regmove_unit #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .instr(instr), .xfer(xfer), .pl_we(pl_we),
    .pl_sel(pl_sel), .pl_data(pl_data), .reg_q(reg_q), .bus_q(bus_q)
  );

  task automatic check(string req, int unsigned act, int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check the bus, let the rising edge act, check the registers.
  task automatic cyc(bit r, int unsigned src, int unsigned dst, bit x,
                     bit pw, int unsigned ps, int unsigned pd);
    string tag;
    rst = r; instr = {dst[1:0], src[1:0]}; xfer = x;
    pl_we = pw; pl_sel = ps[1:0]; pl_data = pd[DW-1:0];
    #1;
    if (!r) check("R2 bus", bus_q, model[src]);
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < NR; i++) model[i] = 0;
    end else if (x) begin
      model[dst] = model[src];
    end else if (pw) begin
      model[ps] = pd & ((1 << DW) - 1);
    end
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      if (r) tag = "R1 reset";
      else if (x && pw) tag = "R8 preload ignored";
      else if (x && src == dst) tag = "R6 self move";
      else if (x) tag = (i == int'(dst)) ? "R3 move" : "R4 others hold";
      else if (pw) tag = "R7 preload";
      else tag = "R5 idle";
      check(tag, reg_q[i*DW +: DW], model[i]);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 0;
    rst = 1'b1; instr = '0; xfer = 0; pl_we = 0; pl_sel = '0; pl_data = '0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, 0);                  // R1
    for (int i = 0; i < NR; i++) cyc(0, 0, 0, 0, 1, i, 8'h11 * (i + 1) + 8'h40); // R7
    cyc(0, 1, 3, 0, 0, 0, 0);                  // R5 instr changes alone
    cyc(0, 2, 0, 1, 0, 0, 0);                  // R3 R0 <= R2
    cyc(0, 3, 1, 1, 0, 0, 0);                  // R3 R1 <= R3
    cyc(0, 2, 2, 1, 0, 0, 0);                  // R6
    cyc(0, 0, 3, 1, 1, 3, 8'hEE);              // R8
    cyc(0, 1, 2, 0, 1, 2, 8'hFF);              // R7 max value
    cyc(0, 2, 1, 1, 0, 0, 0);                  // R3
    for (int k = 0; k < 300; k++) begin
      int unsigned s, d, p, v;
      bit x, w;
      s = $urandom % NR; d = $urandom % NR; p = $urandom % NR;
      v = $urandom % 256; x = 1'($urandom); w = 1'($urandom);
      cyc(($urandom % 64) == 0, s, d, x, w, p, v);
    end
    cyc(1, 0, 0, 1, 1, 1, 8'h55);              // R1 reset wins
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule